// File: doc/BRIEF.md
# Dual-State Branch Target Unit

This execute-stage unit resolves where control goes next for a processor that runs in one of two instruction states: a wide state with 4-byte instructions and a compact state with 2-byte instructions. Each cycle it takes the current program counter, the current state, a decoded branch kind, a signed immediate offset, a register operand and a condition-pass flag. The fetch unit also supplies the sequential PC. From these it produces the next PC, the next state, and a link-register write request with its value.

Relative targets wrap inside the low 32 bits of the address, and any address bits above bit 31 pass through unchanged. Exchange branches change the instruction state. Link values encode the return state in bit 0. Compare-with-zero branches test the register operand and ignore the condition flag. All outputs are registered, so the result appears one clock after the inputs.

Top module: `dual_state_branch_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next edge clears `link_we`, `nxt_pc` and `nxt_compact` to zero.
- R2: Kind code 1 (plain jump) with `cond_pass` high gives next PC = {cur_pc[63:32], cur_pc[31:0] + sign-extended imm (mod 2^32)}. The state is unchanged and there is no link write.
- R3: Kind code 2 (jump with link) with `cond_pass` high takes the R2 target and writes the link. In the wide state the link value is cur_pc - 4. In the compact state it is cur_pc with bit 0 set.
- R4: Kind code 3 (immediate exchange call) with `cond_pass` high targets base + imm, wrapped as in R2. The base is cur_pc[31:0] with bits 1:0 cleared when leaving the compact state, and cur_pc[31:0] unmodified when leaving the wide state.
- R5: Kind code 3 with `cond_pass` high inverts the state and writes the link. The link is cur_pc - 4 in the wide state and cur_pc with bit 0 set in the compact state, with no -2 adjustment.
- R6: Kind code 4 (register exchange call) with `cond_pass` high writes the link. The link is cur_pc - 4 in the wide state and (cur_pc - 2) with bit 0 set in the compact state.
- R7: Kind codes 4 and 5 (register exchange) with `cond_pass` high give next PC = reg_op with bit 0 cleared and next state = reg_op[0], where 1 means compact. Kind 5 writes no link.
- R8: Kind code 6 branches to the R2 target when reg_op is zero, and kind code 7 branches to it when reg_op is non-zero. Both ignore `cond_pass`. When not taken, next PC = seq_pc. Neither writes a link or changes the state.
- R9: Kind codes 1 to 5 with `cond_pass` low give next PC = seq_pc, no link write, and an unchanged state.
- R10: Kind code 0 (no branch) gives next PC = seq_pc, no link write, and an unchanged state, whatever the other inputs are.
- R11: Every output reflects the inputs sampled at the previous rising edge, so latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | ADDR_W | PC value seen by the branch |
| cur_compact | input | 1 | Current state, 1 = compact (2-byte) |
| seq_pc | input | ADDR_W | Fall-through PC |
| kind | input | 3 | Branch kind code 0..7 |
| imm | input | IMM_W | Signed offset |
| reg_op | input | ADDR_W | Register operand |
| cond_pass | input | 1 | Condition evaluated true |
| nxt_pc | output | ADDR_W | Registered next PC |
| nxt_compact | output | 1 | Registered next state |
| link_we | output | 1 | Registered link-write enable |
| link_val | output | ADDR_W | Registered link value |

## Verification
Directed cases put the PC just below the 32-bit wrap point, with non-zero upper bits and with a negative offset. These show whether the addition wraps inside 32 bits and leaves bits above bit 31 untouched. Exchange calls are driven with PCs whose bit 1 is set, in both states. This separates the rounded base from the plain base and the -2 link from the plain link. Compare-with-zero kinds are driven with zero and non-zero operands under both condition values, which shows the condition flag is truly ignored. Constrained-random kinds, PCs, offsets and condition flags, with operands biased toward zero, then check every path against a bench model.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [2:0] {
    BK_NONE      = 3'd0,
    BK_JUMP      = 3'd1,
    BK_CALL      = 3'd2,
    BK_XCALL_IMM = 3'd3,
    BK_XCALL_REG = 3'd4,
    BK_XJUMP_REG = 3'd5,
    BK_ZJUMP     = 3'd6,
    BK_NZJUMP    = 3'd7
  } br_kind_e;
endpackage

// File: rtl/bt_rel_target.sv
// Relative target: low WRAP_W bits wrap, upper bits pass through.
module bt_rel_target #(
  parameter int ADDR_W = 64,
  parameter int WRAP_W = 32,
  parameter int IMM_W  = 25
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [IMM_W-1:0]  imm,
  input  logic              align4,
  output logic [ADDR_W-1:0] tgt
);
  localparam int EXT_W = WRAP_W - IMM_W;

  logic [WRAP_W-1:0] base_lo;
  logic [WRAP_W-1:0] imm_ext;
  logic [WRAP_W-1:0] sum_lo;

  always_comb begin
    base_lo = pc[WRAP_W-1:0];
    if (align4) base_lo[1:0] = 2'b00;
    imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    sum_lo  = base_lo + imm_ext;
  end

  generate
    if (ADDR_W > WRAP_W) begin : g_keep_upper
      assign tgt = {pc[ADDR_W-1:WRAP_W], sum_lo};
    end else begin : g_flat
      assign tgt = sum_lo;
    end
  endgenerate
endmodule

// File: rtl/bt_link_calc.sv
// Return address with the return state encoded in bit 0.
module bt_link_calc #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              compact,
  input  logic              minus2,
  output logic [ADDR_W-1:0] link
);
  localparam logic [ADDR_W-1:0] DEC4 = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] DEC2 = ADDR_W'(2);

  logic [ADDR_W-1:0] cbase;

  always_comb begin
    cbase = minus2 ? (pc - DEC2) : pc;
    if (compact) begin
      link    = cbase;
      link[0] = 1'b1;
    end else begin
      link = pc - DEC4;
    end
  end
endmodule

// File: rtl/dual_state_branch_unit.sv
module dual_state_branch_unit #(
  parameter int ADDR_W = 64,
  parameter int WRAP_W = 32,
  parameter int IMM_W  = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              cur_compact,
  input  logic [ADDR_W-1:0] seq_pc,
  input  logic [2:0]        kind,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ADDR_W-1:0] reg_op,
  input  logic              cond_pass,
  output logic [ADDR_W-1:0] nxt_pc,
  output logic              nxt_compact,
  output logic              link_we,
  output logic [ADDR_W-1:0] link_val
);
  import bt_pkg::*;

  br_kind_e          k;
  logic [ADDR_W-1:0] rel_tgt;
  logic [ADDR_W-1:0] reg_tgt;
  logic [ADDR_W-1:0] link_c;
  logic              op_zero;
  logic [ADDR_W-1:0] pc_d;
  logic              st_d;
  logic              we_d;

  assign k       = br_kind_e'(kind);
  assign op_zero = (reg_op == '0);
  assign reg_tgt = {reg_op[ADDR_W-1:1], 1'b0};

  bt_rel_target #(.ADDR_W(ADDR_W), .WRAP_W(WRAP_W), .IMM_W(IMM_W)) u_rel (
    .pc     (cur_pc),
    .imm    (imm),
    .align4 ((k == BK_XCALL_IMM) && cur_compact),
    .tgt    (rel_tgt)
  );

  bt_link_calc #(.ADDR_W(ADDR_W)) u_link (
    .pc      (cur_pc),
    .compact (cur_compact),
    .minus2  (k == BK_XCALL_REG),
    .link    (link_c)
  );

  always_comb begin
    pc_d = seq_pc;
    st_d = cur_compact;
    we_d = 1'b0;
    unique case (k)
      BK_JUMP, BK_CALL: if (cond_pass) begin
        pc_d = rel_tgt;
        we_d = (k == BK_CALL);
      end
      BK_XCALL_IMM: if (cond_pass) begin
        pc_d = rel_tgt;
        st_d = ~cur_compact;
        we_d = 1'b1;
      end
      BK_XCALL_REG, BK_XJUMP_REG: if (cond_pass) begin
        pc_d = reg_tgt;
        st_d = reg_op[0];
        we_d = (k == BK_XCALL_REG);
      end
      BK_ZJUMP:  if (op_zero)  pc_d = rel_tgt;
      BK_NZJUMP: if (!op_zero) pc_d = rel_tgt;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_pc      <= '0;
      nxt_compact <= 1'b0;
      link_we     <= 1'b0;
      link_val    <= '0;
    end else begin
      nxt_pc      <= pc_d;
      nxt_compact <= st_d;
      link_we     <= we_d;
      link_val    <= link_c;
    end
  end
endmodule

// File: rtl/bt_branch_checker.sv
module bt_branch_checker #(
  parameter int ADDR_W = 64,
  parameter int WRAP_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cur_pc,
  input logic              cur_compact,
  input logic [ADDR_W-1:0] seq_pc,
  input logic [2:0]        kind,
  input logic [ADDR_W-1:0] reg_op,
  input logic              cond_pass,
  input logic [ADDR_W-1:0] nxt_pc,
  input logic              nxt_compact,
  input logic              link_we,
  input logic [ADDR_W-1:0] link_val
);
  localparam logic [ADDR_W-1:0] C1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] C2 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] C4 = ADDR_W'(4);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!link_we && nxt_pc == '0 && !nxt_compact));

  a_r5_imm_exchange_toggles: assert property (@(posedge clk) disable iff (rst)
    (kind == 3'd3 && cond_pass) |=> (nxt_compact != $past(cur_compact) && link_we));

  a_r6_reg_call_compact_link: assert property (@(posedge clk) disable iff (rst)
    (kind == 3'd4 && cond_pass && cur_compact) |=>
      (link_we && link_val == (($past(cur_pc) - C2) | C1)));

  a_r3_wide_link: assert property (@(posedge clk) disable iff (rst)
    ((kind == 3'd2 || kind == 3'd3 || kind == 3'd4) && cond_pass && !cur_compact) |=>
      (link_val == $past(cur_pc) - C4));

  a_r7_reg_exchange: assert property (@(posedge clk) disable iff (rst)
    ((kind == 3'd4 || kind == 3'd5) && cond_pass) |=>
      (nxt_pc == ($past(reg_op) & ~C1) && nxt_compact == $past(reg_op[0])));

  a_r8_zero_no_link: assert property (@(posedge clk) disable iff (rst)
    (kind == 3'd6 || kind == 3'd7) |=> (!link_we && nxt_compact == $past(cur_compact)));

  a_r9_cond_fail: assert property (@(posedge clk) disable iff (rst)
    (kind >= 3'd1 && kind <= 3'd5 && !cond_pass) |=>
      (nxt_pc == $past(seq_pc) && !link_we && nxt_compact == $past(cur_compact)));

  a_r10_no_branch: assert property (@(posedge clk) disable iff (rst)
    (kind == 3'd0) |=> (nxt_pc == $past(seq_pc) && !link_we));

  generate
    if (ADDR_W > WRAP_W) begin : g_upper
      a_r2_upper_kept: assert property (@(posedge clk) disable iff (rst)
        ((kind == 3'd1 || kind == 3'd2) && cond_pass) |=>
          (nxt_pc[ADDR_W-1:WRAP_W] == $past(cur_pc[ADDR_W-1:WRAP_W])));
    end
  endgenerate
endmodule

bind dual_state_branch_unit bt_branch_checker #(.ADDR_W(ADDR_W), .WRAP_W(WRAP_W)) u_chk (
  .clk(clk), .rst(rst), .cur_pc(cur_pc), .cur_compact(cur_compact), .seq_pc(seq_pc),
  .kind(kind), .reg_op(reg_op), .cond_pass(cond_pass), .nxt_pc(nxt_pc),
  .nxt_compact(nxt_compact), .link_we(link_we), .link_val(link_val)
);

// File: tb/dual_state_branch_unit_bench.sv
module dual_state_branch_unit_bench;
  localparam int AW = 64;
  localparam int IW = 25;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] cur_pc, seq_pc, reg_op;
  logic          cur_compact, cond_pass;
  logic [2:0]    kind;
  logic [IW-1:0] imm;
  logic [AW-1:0] nxt_pc, link_val;
  logic          nxt_compact, link_we;

  int n_checks = 0;
  int n_errs   = 0;

  always #2 clk = ~clk;

  dual_state_branch_unit u_dual_state_branch_unit (
    .clk(clk), .rst(rst), .cur_pc(cur_pc), .cur_compact(cur_compact),
    .seq_pc(seq_pc), .kind(kind), .imm(imm), .reg_op(reg_op),
    .cond_pass(cond_pass), .nxt_pc(nxt_pc), .nxt_compact(nxt_compact),
    .link_we(link_we), .link_val(link_val)
  );

  task automatic check(input string req, input string what, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] k, input logic c);
    if (k == 3'd0) return "R10";
    if (k >= 3'd6) return "R8";
    if (!c) return "R9";
    case (k)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4/R5";
      3'd4: return "R6/R7";
      default: return "R7";
    endcase
  endfunction

  task automatic apply(input logic [2:0] k, input logic [AW-1:0] pc, input logic cs,
                       input logic [IW-1:0] im, input logic [AW-1:0] op,
                       input logic c, input logic [AW-1:0] sq);
    logic [31:0]   base, sum;
    logic [AW-1:0] rel, e_pc, e_lv;
    logic          e_st, e_we, taken;
    string         rq;
    @(negedge clk);
    kind = k; cur_pc = pc; cur_compact = cs; imm = im; reg_op = op;
    cond_pass = c; seq_pc = sq;
    base = pc[31:0];
    if (k == 3'd3 && cs) base = base & 32'hFFFF_FFFC;
    sum = base + {{7{im[IW-1]}}, im};
    rel = {pc[63:32], sum};
    e_pc = sq; e_st = cs; e_we = 1'b0; e_lv = '0;
    taken = (k == 3'd6) ? (op == '0) : (k == 3'd7) ? (op != '0) : (k != 3'd0 && c);
    if (taken) begin
      if (k == 3'd4 || k == 3'd5) begin
        e_pc = op & ~64'd1; e_st = op[0];
      end else e_pc = rel;
      if (k == 3'd3) e_st = ~cs;
      e_we = (k >= 3'd2 && k <= 3'd4);
      if (!cs) e_lv = pc - 64'd4;
      else if (k == 3'd4) e_lv = (pc - 64'd2) | 64'd1;
      else e_lv = pc | 64'd1;
    end
    rq = req_of(k, c);
    // R11: result visible after exactly one rising edge
    @(negedge clk);
    check({rq, " R11"}, "next pc", nxt_pc, e_pc);
    check({rq, " R11"}, "next state", AW'(nxt_compact), AW'(e_st));
    check(rq, "link enable", AW'(link_we), AW'(e_we));
    if (e_we) check(rq, "link value", link_val, e_lv);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; kind = 3'd0; cur_pc = '0; cur_compact = 1'b0; imm = '0;
    reg_op = '0; cond_pass = 1'b0; seq_pc = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "pc after reset", nxt_pc, '0);
    check("R1", "link enable after reset", AW'(link_we), '0);
    check("R1", "state after reset", AW'(nxt_compact), '0);
    rst = 1'b0;

    // R2: wrap at 32 bits with upper bits kept
    apply(3'd1, 64'hABCD_0001_FFFF_FFF0, 1'b0, 25'h20, '0, 1'b1, 64'h10);
    apply(3'd1, 64'h0000_0005_0000_0008, 1'b1, 25'h1FF_FFF0, '0, 1'b1, 64'h10);
    // R3: link in both states
    apply(3'd2, 64'h0000_0000_0000_1000, 1'b0, 25'h40, '0, 1'b1, 64'h1004);
    apply(3'd2, 64'h0000_0000_0000_1002, 1'b1, 25'h40, '0, 1'b1, 64'h1004);
    // R4/R5: exchange call, rounded base in compact state
    apply(3'd3, 64'h0000_0001_0000_2006, 1'b1, 25'h100, '0, 1'b1, 64'h0);
    apply(3'd3, 64'h0000_0001_0000_2006, 1'b0, 25'h100, '0, 1'b1, 64'h0);
    // R6/R7: register exchange call and jump
    apply(3'd4, 64'h0000_0000_0000_3006, 1'b1, '0, 64'h8000_0001, 1'b1, 64'h0);
    apply(3'd4, 64'h0000_0000_0000_3008, 1'b0, '0, 64'h8000_0000, 1'b1, 64'h0);
    apply(3'd5, 64'h0000_0000_0000_3008, 1'b0, '0, 64'h7777_0003, 1'b1, 64'h0);
    // R8: compare-with-zero ignores condition
    apply(3'd6, 64'h100, 1'b1, 25'h8, '0, 1'b0, 64'h102);
    apply(3'd6, 64'h100, 1'b1, 25'h8, 64'h1, 1'b1, 64'h102);
    apply(3'd7, 64'h100, 1'b1, 25'h8, 64'h1, 1'b0, 64'h102);
    apply(3'd7, 64'h100, 1'b1, 25'h8, '0, 1'b1, 64'h102);
    // R9: failed condition
    apply(3'd3, 64'h2000, 1'b1, 25'h8, 64'h5, 1'b0, 64'h2004);
    apply(3'd4, 64'h2000, 1'b0, 25'h8, 64'h5, 1'b0, 64'h2004);
    // R10: no branch
    apply(3'd0, 64'h2000, 1'b1, 25'h8, 64'h5, 1'b1, 64'h2002);

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] op;
      op = ($urandom % 4 == 0) ? '0 : {$urandom, $urandom};
      apply(3'($urandom), {$urandom, $urandom}, 1'($urandom), IW'($urandom), op,
            1'($urandom), {$urandom, $urandom});
    end
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #400000;
    n_errs++;
    n_checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule